// File: doc/BRIEF.md
# Paged Event Fragment Input Manager

This block sits behind the receive FIFO of a point-to-point data link. Every accepted word is 32 bits wide and comes with a flag that says whether it is a control word or a data word. Begin and end control words split the stream into events. Every word that belongs to an event, the two control words included, goes to page memory. Memory is handed out in fixed-size pages, and page numbers come from an external free-page FIFO that presents its head entry without a read (first-word-fall-through). When an event closes, the block emits one descriptor for the used-page FIFO. The descriptor holds the first page, the page count, the stored word count and a status field of error flags collected over the event.

The block also drives two flow-control outputs. The link stop request combines a software bit, the input FIFO almost-full mark and a free-page low-water threshold. The trigger hold-off compares the free-page level against a threshold of its own.

Top module: `evt_page_mgr`

## Requirements
- R1: A control word with bit 30 set is a begin marker. A control word with bit 30 clear is an end marker. No other bit takes part in this decision, and both markers are stored like data when they belong to an event.
- R2: A data word that arrives while no event is open is dropped. It causes no memory write, no page pop and no descriptor.
- R3: A begin marker that arrives while an event is open closes that event first. The closed event's descriptor leaves with status bit 0 (begin-without-end) set and does not count the new marker. The marker then opens the new event and is stored as its first word.
- R4: An end marker that arrives while no event is open produces one descriptor with status bit 1 (end-without-begin) set. All its other fields and bits are zero, and nothing is written to memory.
- R5: Stored words of an event fill consecutive word offsets of the current page. The memory address is {page, offset}. When a word needs a new page, the block pops the free FIFO (freeRdEn high in that cycle) and writes the word at offset 0 of the popped page. The memory write appears one clock after the word is presented.
- R6: When an event closes, the descriptor appears one clock after the closing word. It carries the first page number, the number of pages taken and the number of words stored, end marker included.
- R7: Status bit 3 is set when the link error input or either of data bits 1:0 is high on any word of the event, whether that word is stored or not.
- R8: An event takes at most MAX_PAGES pages. Words that would need a further page are discarded, are not counted, and set status bit 2 (truncated).
- R9: When a word needs a page and the free FIFO is empty, the word is discarded and status bit 4 (starved) is set. The event goes on and takes a page as soon as one is available.
- R10: xoff is high when the software stop bit is set, or the input FIFO almost-full input is high, or the free level is below xoffThresh.
- R11: trigInhibit is high exactly when the free level is below inhibitThresh, whatever xoffThresh is.
- R12: During and right after reset, no event is open and neither a memory write nor a descriptor is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A link word is presented this cycle |
| inCtrl | input | 1 | Presented word is a control word |
| inData | input | 32 | Link word |
| linkErr | input | 1 | Link error line for this word |
| inFifoAlmostFull | input | 1 | Input FIFO almost-full mark |
| swXoff | input | 1 | Software stop request |
| xoffThresh | input | PAGE_BITS+1 | Free level below which xoff rises |
| inhibitThresh | input | PAGE_BITS+1 | Free level below which trigInhibit rises |
| freeLevel | input | PAGE_BITS+1 | Entries in the free-page FIFO |
| freePage | input | PAGE_BITS | Head entry of the free-page FIFO |
| freeRdEn | output | 1 | Pop the free-page FIFO |
| memWe | output | 1 | Page memory write strobe |
| memAddr | output | PAGE_BITS+log2(PAGE_WORDS) | Page memory address {page, offset} |
| memData | output | 32 | Page memory write data |
| usedWe | output | 1 | Push descriptor to the used-page FIFO |
| usedFirst | output | PAGE_BITS | Descriptor: first page |
| usedPages | output | log2(MAX_PAGES+1) | Descriptor: page count |
| usedWords | output | log2(MAX_PAGES*PAGE_WORDS+1) | Descriptor: stored word count |
| usedStatus | output | 5 | Descriptor: error flags |
| xoff | output | 1 | Link stop request |
| trigInhibit | output | 1 | Trigger hold-off |

## Verification
The assertions assume the free-page FIFO is honest. freeLevel must give the true number of entries, and freePage must hold the head entry whenever that level is nonzero. They also assume that inputs change only away from the rising clock edge. The bench models the free FIFO as a queue. It updates the level and head only after a pop at the edge or during a refill between edges, and it drives every link word at the falling edge. This keeps the design's view of page availability the same as the one the expected values are computed from.

// File: rtl/evt_page_pkg.sv
package evt_page_pkg;

  // Status field bit positions in the used-page descriptor
  localparam int ST_BWE    = 0;
  localparam int ST_EWB    = 1;
  localparam int ST_TRUNC  = 2;
  localparam int ST_LINK   = 3;
  localparam int ST_STARVE = 4;
  localparam int ST_W      = 5;

  // Strobes from framing control to the page datapath
  typedef struct packed {
    logic openEvt;   // begin marker starts a new event
    logic closeEvt;  // a descriptor leaves this cycle
    logic inEvt;     // word belongs to an open or opening event
    logic store;     // word is written to page memory
    logic alloc;     // a free page is popped for this word
    logic bwe;       // begin arrived with an event still open
    logic ewb;       // end arrived with no event open
    logic trunc;     // page cap reached, word discarded
    logic starve;    // no free page, word discarded
  } evtStrb_t;

endpackage

// File: rtl/evt_frame_ctrl.sv
module evt_frame_ctrl
  import evt_page_pkg::*;
#(
  parameter int MAX_PAGES = 3,
  parameter int CW = 2,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inCtrl,
  input  logic          inBit30,
  input  logic [CW-1:0] pageCnt,
  input  logic [OW-1:0] wordOff,
  input  logic          freeAvail,
  output evtStrb_t      strb,
  output logic          openQ
);

  logic isBegin, isEnd, needPage, atCap;

  always_comb begin
    isBegin  = inValid & inCtrl & inBit30;
    isEnd    = inValid & inCtrl & ~inBit30;
    needPage = isBegin | (wordOff == '0);
    atCap    = ~isBegin & (pageCnt == CW'(MAX_PAGES));

    strb          = '0;
    strb.openEvt  = isBegin;
    strb.inEvt    = isBegin | (inValid & openQ);
    strb.bwe      = isBegin & openQ;
    strb.ewb      = isEnd & ~openQ;
    strb.closeEvt = strb.bwe | isEnd;
    strb.alloc    = strb.inEvt & needPage & ~atCap & freeAvail;
    strb.store    = strb.inEvt & (~needPage | strb.alloc);
    strb.trunc    = strb.inEvt & needPage & atCap;
    strb.starve   = strb.inEvt & needPage & ~atCap & ~freeAvail;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        openQ <= 1'b0;
    else if (isBegin) openQ <= 1'b1;
    else if (isEnd)   openQ <= 1'b0;
  end

endmodule

// File: rtl/evt_page_dp.sv
module evt_page_dp
  import evt_page_pkg::*;
#(
  parameter int PAGE_WORDS = 4,
  parameter int MAX_PAGES  = 3,
  parameter int PAGE_BITS  = 4,
  localparam int OW = $clog2(PAGE_WORDS),
  localparam int CW = $clog2(MAX_PAGES + 1),
  localparam int WW = $clog2(MAX_PAGES * PAGE_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  evtStrb_t              strb,
  input  logic [31:0]           inData,
  input  logic                  linkErr,
  input  logic [PAGE_BITS-1:0]  freePage,
  output logic [CW-1:0]         pageCnt,
  output logic [OW-1:0]         wordOff,
  output logic                  memWe,
  output logic [PAGE_BITS+OW-1:0] memAddr,
  output logic [31:0]           memData,
  output logic                  usedWe,
  output logic [PAGE_BITS-1:0]  usedFirst,
  output logic [CW-1:0]         usedPages,
  output logic [WW-1:0]         usedWords,
  output logic [ST_W-1:0]       usedStatus
);

  logic [PAGE_BITS-1:0] curPage, firstPage, bFirst, nFirst, usePage;
  logic [CW-1:0]        bPages, nPages;
  logic [WW-1:0]        wordCnt, bWords, nWords;
  logic [OW-1:0]        bOff, nOff;
  logic [ST_W-1:0]      stat, bStat, nStat, closeStat;

  always_comb begin
    bFirst  = strb.openEvt ? '0 : firstPage;
    bPages  = strb.openEvt ? '0 : pageCnt;
    bWords  = strb.openEvt ? '0 : wordCnt;
    bOff    = strb.openEvt ? '0 : wordOff;
    bStat   = strb.openEvt ? '0 : stat;
    usePage = strb.alloc ? freePage : curPage;
    nFirst  = (strb.alloc && bPages == '0) ? freePage : bFirst;
    nPages  = bPages + CW'(strb.alloc);
    nWords  = bWords + WW'(strb.store);
    nOff    = bOff;
    if (strb.store)
      nOff = (bOff == OW'(PAGE_WORDS - 1)) ? '0 : bOff + OW'(1);
    nStat = bStat;
    nStat[ST_TRUNC]  = bStat[ST_TRUNC]  | strb.trunc;
    nStat[ST_STARVE] = bStat[ST_STARVE] | strb.starve;
    nStat[ST_LINK]   = bStat[ST_LINK]   | (strb.inEvt & (linkErr | (|inData[1:0])));
    closeStat = '0;
    if (strb.ewb)      closeStat[ST_EWB] = 1'b1;
    else if (strb.bwe) begin
      closeStat = stat;
      closeStat[ST_BWE] = 1'b1;
    end else           closeStat = nStat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage <= '0; firstPage <= '0; pageCnt <= '0;
      wordCnt <= '0; wordOff <= '0; stat <= '0;
      memWe <= 1'b0; memAddr <= '0; memData <= '0;
      usedWe <= 1'b0; usedFirst <= '0; usedPages <= '0;
      usedWords <= '0; usedStatus <= '0;
    end else begin
      if (strb.inEvt) begin
        curPage   <= usePage;
        firstPage <= nFirst;
        pageCnt   <= nPages;
        wordCnt   <= nWords;
        wordOff   <= nOff;
        stat      <= nStat;
      end
      memWe   <= strb.store;
      memAddr <= {usePage, bOff};
      memData <= inData;
      usedWe  <= strb.closeEvt;
      if (strb.closeEvt) begin
        usedFirst  <= strb.ewb ? '0 : (strb.bwe ? firstPage : nFirst);
        usedPages  <= strb.ewb ? '0 : (strb.bwe ? pageCnt : nPages);
        usedWords  <= strb.ewb ? '0 : (strb.bwe ? wordCnt : nWords);
        usedStatus <= closeStat;
      end
    end
  end

  // R8
  page_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedWe |-> int'(usedPages) <= MAX_PAGES);

  // R4
  ewb_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (usedWe && usedStatus[ST_EWB]) |-> (usedPages == '0 && usedWords == '0));

  // R6
  word_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedWe |-> int'(usedWords) <= int'(usedPages) * PAGE_WORDS);

endmodule

// File: rtl/evt_page_mgr.sv
module evt_page_mgr
  import evt_page_pkg::*;
#(
  parameter int PAGE_WORDS = 4,
  parameter int MAX_PAGES  = 3,
  parameter int PAGE_BITS  = 4,
  localparam int OW = $clog2(PAGE_WORDS),
  localparam int CW = $clog2(MAX_PAGES + 1),
  localparam int WW = $clog2(MAX_PAGES * PAGE_WORDS + 1),
  localparam int LW = PAGE_BITS + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inCtrl,
  input  logic [31:0]             inData,
  input  logic                    linkErr,
  input  logic                    inFifoAlmostFull,
  input  logic                    swXoff,
  input  logic [LW-1:0]           xoffThresh,
  input  logic [LW-1:0]           inhibitThresh,
  input  logic [LW-1:0]           freeLevel,
  input  logic [PAGE_BITS-1:0]    freePage,
  output logic                    freeRdEn,
  output logic                    memWe,
  output logic [PAGE_BITS+OW-1:0] memAddr,
  output logic [31:0]             memData,
  output logic                    usedWe,
  output logic [PAGE_BITS-1:0]    usedFirst,
  output logic [CW-1:0]           usedPages,
  output logic [WW-1:0]           usedWords,
  output logic [ST_W-1:0]         usedStatus,
  output logic                    xoff,
  output logic                    trigInhibit
);

  evtStrb_t      strb;
  logic          openQ;
  logic [CW-1:0] pageCnt;
  logic [OW-1:0] wordOff;

  evt_frame_ctrl #(.MAX_PAGES(MAX_PAGES), .CW(CW), .OW(OW)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCtrl(inCtrl),
    .inBit30(inData[30]), .pageCnt(pageCnt), .wordOff(wordOff),
    .freeAvail(freeLevel != '0), .strb(strb), .openQ(openQ)
  );

  evt_page_dp #(.PAGE_WORDS(PAGE_WORDS), .MAX_PAGES(MAX_PAGES), .PAGE_BITS(PAGE_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .linkErr(linkErr),
    .freePage(freePage), .pageCnt(pageCnt), .wordOff(wordOff),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .usedWe(usedWe), .usedFirst(usedFirst), .usedPages(usedPages),
    .usedWords(usedWords), .usedStatus(usedStatus)
  );

  assign freeRdEn    = strb.alloc;
  assign xoff        = swXoff | inFifoAlmostFull | (freeLevel < xoffThresh);
  assign trigInhibit = freeLevel < inhibitThresh;

  // R2
  orphan_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inCtrl && !openQ) |=> !memWe);

  // R5
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeRdEn |-> freeLevel != '0);

  // R5
  page_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[OW-1:0] == '0) |-> $past(freeRdEn));

endmodule

// File: tb/test_evt_page_mgr.sv
module test_evt_page_mgr;

  localparam int PWORDS = 4;
  localparam int MAXP   = 3;
  localparam int PB     = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inCtrl = 1'b0, linkErr = 1'b0;
  logic [31:0] inData = '0;
  logic        inFifoAlmostFull = 1'b0, swXoff = 1'b0;
  logic [4:0]  xoffThresh = '0, inhibitThresh = '0, freeLevel = '0;
  logic [3:0]  freePage = '0;
  logic        freeRdEn, memWe, usedWe, xoff, trigInhibit;
  logic [5:0]  memAddr;
  logic [31:0] memData;
  logic [3:0]  usedFirst;
  logic [1:0]  usedPages;
  logic [3:0]  usedWords;
  logic [4:0]  usedStatus;

  int checks = 0, errors = 0;
  string curTag = "R12";

  logic [3:0]  freeQ[$];
  logic [37:0] memQ[$];
  string       memTagQ[$];
  logic [14:0] descQ[$];
  string       descTagQ[$];

  int         mOpen = 0, mPages = 0, mWords = 0, mOff = 0;
  logic [3:0] mFirst = '0, mCur = '0;
  logic [4:0] mStat = '0;

  always #4 clk = ~clk;

  evt_page_mgr #(.PAGE_WORDS(PWORDS), .MAX_PAGES(MAXP), .PAGE_BITS(PB)) i_evt_page_mgr (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCtrl(inCtrl), .inData(inData),
    .linkErr(linkErr), .inFifoAlmostFull(inFifoAlmostFull), .swXoff(swXoff),
    .xoffThresh(xoffThresh), .inhibitThresh(inhibitThresh), .freeLevel(freeLevel),
    .freePage(freePage), .freeRdEn(freeRdEn), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .usedWe(usedWe), .usedFirst(usedFirst), .usedPages(usedPages),
    .usedWords(usedWords), .usedStatus(usedStatus), .xoff(xoff), .trigInhibit(trigInhibit)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Free-page FIFO model: pop at the edge, publish head and level with NBA
  always @(posedge clk) begin
    if (freeRdEn && freeQ.size() > 0) void'(freeQ.pop_front());
    freeLevel <= 5'(freeQ.size());
    freePage  <= (freeQ.size() > 0) ? freeQ[0] : 4'd0;
  end

  task automatic fillFree(input int base, input int n);
    freeQ.delete();
    for (int i = 0; i < n; i++) freeQ.push_back(4'((base + i) % 16));
    freeLevel = 5'(n);
    freePage  = (n > 0) ? freeQ[0] : 4'd0;
  endtask

  task automatic pushMem(input logic [3:0] pg, input int off, input logic [31:0] d);
    memQ.push_back({pg, 2'(off), d});
    memTagQ.push_back(curTag);
  endtask

  task automatic pushDesc(input logic [3:0] f, input int p, input int w, input logic [4:0] s);
    descQ.push_back({f, 2'(p), 4'(w), s});
    descTagQ.push_back(curTag);
  endtask

  // Driver: computes expectations from the requirements, then presents the word
  task automatic sendWord(input logic c, input logic [31:0] d, input logic e);
    logic [3:0] pg;
    if (c && d[30]) begin
      if (mOpen != 0) pushDesc(mFirst, mPages, mWords, mStat | 5'b00001);
      mOpen = 1; mFirst = '0; mPages = 0; mWords = 0; mOff = 0; mStat = '0;
    end else if (c && mOpen == 0) begin
      pushDesc(4'd0, 0, 0, 5'b00010);
    end
    if (mOpen != 0) begin
      if (e || d[1:0] != 2'b00) mStat = mStat | 5'b01000;
      if (mOff == 0) begin
        if (mPages == MAXP) mStat = mStat | 5'b00100;
        else if (freeQ.size() == 0) mStat = mStat | 5'b10000;
        else begin
          pg = freeQ[0];
          if (mPages == 0) mFirst = pg;
          mPages++; mCur = pg;
          pushMem(pg, 0, d);
          mOff = 1 % PWORDS; mWords++;
        end
      end else begin
        pushMem(mCur, mOff, d);
        mOff = (mOff + 1) % PWORDS; mWords++;
      end
      if (c && !d[30]) begin
        pushDesc(mFirst, mPages, mWords, mStat);
        mOpen = 0;
      end
    end
    inValid = 1'b1; inCtrl = c; inData = d; linkErr = e;
    @(negedge clk);
    inValid = 1'b0; inCtrl = 1'b0; inData = '0; linkErr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (memQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s: unexpected memory write got %h expected none", curTag, {memAddr, memData});
        end else chk(memTagQ.pop_front(), 64'({memAddr, memData}), 64'(memQ.pop_front()));
      end
      if (usedWe) begin
        if (descQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s: unexpected descriptor got %h expected none", curTag,
                   {usedFirst, usedPages, usedWords, usedStatus});
        end else chk(descTagQ.pop_front(), 64'({usedFirst, usedPages, usedWords, usedStatus}),
                     64'(descQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fillFree(0, 16);
    idle(3);
    // R12: quiet outputs under reset
    chk("R12", {memWe, usedWe, freeRdEn}, 3'b000);
    rstN = 1'b1;
    idle(2);
    chk("R12", {memWe, usedWe}, 2'b00);

    // R2: orphan data words before any begin
    curTag = "R2";
    sendWord(1'b0, 32'h1234_5670, 1'b0);
    sendWord(1'b0, 32'h4000_0000, 1'b0);
    idle(3);
    chk("R2", 64'(freeLevel), 64'd16);
    chk("R2", 64'(memQ.size() + descQ.size()), 64'd0);

    // R5 / R6: seven words spanning two pages
    fillFree(3, 8);
    curTag = "R5";
    sendWord(1'b1, 32'h4000_0010, 1'b0);
    for (int i = 1; i <= 5; i++) sendWord(1'b0, 32'h1111_0000 * i, 1'b0);
    curTag = "R6";
    sendWord(1'b1, 32'h0000_0020, 1'b0);
    idle(3);
    chk("R6", 64'(freeLevel), 64'd6);

    // R1: only bit 30 tells markers apart; data with bit 30 stays data
    fillFree(9, 8);
    curTag = "R1";
    sendWord(1'b1, 32'h7ABC_DEF0, 1'b0);
    sendWord(1'b0, 32'hFFFF_FFF0, 1'b0);
    sendWord(1'b1, 32'hBFFF_FFF0, 1'b0);
    sendWord(1'b1, 32'hFFFF_FFFC, 1'b0);
    sendWord(1'b1, 32'h8000_0000, 1'b0);
    idle(3);

    // R7: link error via the line and via each low data bit
    fillFree(1, 8);
    curTag = "R7";
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    sendWord(1'b0, 32'h0000_0100, 1'b1);
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    sendWord(1'b0, 32'h0000_0201, 1'b0);
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    sendWord(1'b1, 32'h0000_0002, 1'b0);
    idle(3);

    // R3: begin while open closes the previous event
    fillFree(4, 8);
    curTag = "R3";
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    sendWord(1'b0, 32'hAAAA_0000, 1'b0);
    sendWord(1'b1, 32'h4000_0040, 1'b0);
    sendWord(1'b0, 32'hBBBB_0000, 1'b0);
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    idle(3);

    // R4: end with nothing open
    curTag = "R4";
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    sendWord(1'b1, 32'h0000_0000, 1'b1);
    idle(3);

    // R8: fifteen words against a twelve-word cap
    fillFree(8, 8);
    curTag = "R8";
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    for (int i = 1; i <= 13; i++) sendWord(1'b0, 32'h0101_0000 * i, 1'b0);
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    idle(3);
    chk("R8", 64'(freeLevel), 64'd5);

    // R9: starved at start, resumes once pages return
    fillFree(0, 0);
    curTag = "R9";
    sendWord(1'b1, 32'h4000_0000, 1'b0);
    sendWord(1'b0, 32'h5555_0000, 1'b0);
    fillFree(12, 2);
    sendWord(1'b0, 32'h6666_0000, 1'b0);
    sendWord(1'b1, 32'h0000_0000, 1'b0);
    idle(3);

    // R10 / R11: flow-control outputs
    fillFree(0, 8);
    idle(1);
    xoffThresh = 5'd3; inhibitThresh = 5'd2; #1;
    chk("R10", xoff, 1'b0);
    chk("R11", trigInhibit, 1'b0);
    inFifoAlmostFull = 1'b1; #1;
    chk("R10", xoff, 1'b1);
    inFifoAlmostFull = 1'b0; swXoff = 1'b1; #1;
    chk("R10", xoff, 1'b1);
    swXoff = 1'b0; xoffThresh = 5'd8; #1;
    chk("R10", xoff, 1'b0);
    xoffThresh = 5'd9; #1;
    chk("R10", xoff, 1'b1);
    xoffThresh = 5'd3; inhibitThresh = 5'd9; #1;
    chk("R11", {trigInhibit, xoff}, 2'b10);
    inhibitThresh = 5'd8; #1;
    chk("R11", trigInhibit, 1'b0);

    idle(2);
    chk("R6", 64'(descQ.size()), 64'd0);
    chk("R5", 64'(memQ.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule